// File: doc/BRIEF.md
# Satellite Control Command Envelope Transmitter

This block turns a short satellite-control command into the on/off gate of a tone carrier. A host places up to `MAX_BYTES` message bytes on `msg_data` (byte 0 in the lowest eight bits is sent first). It sets `msg_len` and a burst selector, then pulses `start` for one cycle. The block first holds the gate off for a quiet gap. It then sends every byte as nine pulse-width-coded symbols: eight data bits and one parity bit. After a second quiet gap it may add a trailing mini-burst. Finally it raises `done` for one cycle. The block only produces the envelope. The carrier oscillator, supply-voltage control and reply reception sit outside it.

All durations are whole microsecond ticks. The tick comes from a divider of ratio `CLK_HZ/1_000_000`, which restarts with every transmission. The state machine moves through these states: IDLE, LEAD_GAP, BIT_ON, BIT_OFF, TRAIL_GAP, TONE_BURST, TAIL_GAP and FINISH. Its transitions are:

- IDLE to LEAD_GAP on `start`.
- LEAD_GAP to BIT_ON when bytes are pending, otherwise to TRAIL_GAP.
- BIT_ON to BIT_OFF.
- BIT_OFF back to BIT_ON for the next bit or the next byte. After the last parity bit it goes to TRAIL_GAP, or to TAIL_GAP when the byte-form burst was being sent.
- TRAIL_GAP to TONE_BURST, to BIT_ON (byte-form burst) or to FINISH, depending on the selector.
- TONE_BURST to TAIL_GAP.
- TAIL_GAP to FINISH.
- FINISH to IDLE.

Top module: `diseqc_env_tx`

## Requirements
- R1: A bit of value 1 drives `tone_en` high for `SHORT_US` ticks and then low for `LONG_US` ticks.
- R2: A bit of value 0 drives `tone_en` high for `LONG_US` ticks and then low for `SHORT_US` ticks.
- R3: Bytes go out in order `msg_data[7:0]` first, each most significant bit first. Each byte is followed by one parity bit equal to 1 XOR all eight data bits (odd parity).
- R4: `tone_en` stays low for `GAP_US` ticks before the first byte and for another `GAP_US` ticks after the last byte.
- R5: `burst_sel` = 2'b10 appends the byte 0xFF with its parity bit, coded as in R1/R2, followed by `TAIL_US` ticks low.
- R6: `burst_sel` = 2'b01 appends `tone_en` high for `TONE_US` ticks, followed by `TAIL_US` ticks low.
- R7: `burst_sel` = 2'b00 or 2'b11 sends no burst and no tail interval. The frame ends right after the trailing gap.
- R8: `msg_len` = 0 is legal and produces only the gaps and the selected burst.
- R9: A `msg_len` greater than `MAX_BYTES` is clamped to `MAX_BYTES`.
- R10: `busy` rises in the cycle after an accepted `start` and stays high through the `done` cycle. A `start` seen while `busy` is high is ignored.
- R11: An asserted (low) `rst_n` forces `tone_en`, `busy` and `done` low at once, without waiting for a clock edge, and returns the block to idle.
- R12: `done` is high for exactly one cycle, the cycle right after the last timed interval. `busy` is low in the following cycle.
- R13: One tick lasts `CLK_HZ/1_000_000` clock cycles. The first interval starts at the clock edge that accepts `start`, and each interval lasts its tick count times that ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to send a frame |
| msg_len | input | LEN_W | Number of message bytes, clamped to MAX_BYTES |
| msg_data | input | MAX_BYTES*8 | Message bytes, byte 0 in bits 7:0 |
| burst_sel | input | 2 | 00/11 no burst, 01 continuous tone, 10 byte 0xFF |
| tone_en | output | 1 | Envelope gate for the tone carrier |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong state register or a wrong bit counter shows up on `tone_en` as a pulse of the wrong width, a missing symbol or a wrong parity symbol. The bench compares the gate against a waveform built from the requirements in every cycle. A fault therefore surfaces within one symbol, a few tens of cycles with the bench timing. A wrong burst decode or a wrong length clamp stretches or shortens the frame, so `done` arrives in the wrong cycle. Faults in the divider or the interval counter scale every width, and the first gap already reveals them.

// File: rtl/diseqc_env_pkg.sv
package diseqc_env_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD_GAP,
        ST_BIT_ON,
        ST_BIT_OFF,
        ST_TRAIL_GAP,
        ST_TONE_BURST,
        ST_TAIL_GAP,
        ST_FINISH
    } tx_state_e;

    typedef enum logic [1:0] {
        BURST_NONE = 2'b00,
        BURST_TONE = 2'b01,
        BURST_BYTE = 2'b10,
        BURST_RSVD = 2'b11
    } burst_sel_e;

endpackage

// File: rtl/diseqc_us_tick.sv
module diseqc_us_tick #(
    parameter int RATIO = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int DW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [DW-1:0] LAST = DW'(RATIO - 1);

    logic [DW-1:0] div_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_cnt <= '0;
        else if (!run || div_cnt == LAST)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + DW'(1);
    end

    assign tick = run && (div_cnt == LAST);
endmodule

// File: rtl/diseqc_seg_timer.sv
module diseqc_seg_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [TW-1:0] seg_len,
    output logic          seg_end
);
    logic [TW-1:0] elapsed;

    assign seg_end = tick && (elapsed == seg_len - TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            elapsed <= '0;
        else if (!run || seg_end)
            elapsed <= '0;
        else if (tick)
            elapsed <= elapsed + TW'(1);
    end
endmodule

// File: rtl/diseqc_env_tx.sv
module diseqc_env_tx
    import diseqc_env_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int MAX_BYTES = 6,
    parameter int LEN_W     = 4,
    parameter int SHORT_US  = 500,
    parameter int LONG_US   = 1000,
    parameter int GAP_US    = 16000,
    parameter int TONE_US   = 12500,
    parameter int TAIL_US   = 20000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [LEN_W-1:0]       msg_len,
    input  logic [MAX_BYTES*8-1:0] msg_data,
    input  logic [1:0]             burst_sel,
    output logic                   tone_en,
    output logic                   busy,
    output logic                   done
);
    localparam int TICK_RATIO = CLK_HZ / 1_000_000;
    localparam int SPAN_US    = SHORT_US + LONG_US + GAP_US + TONE_US + TAIL_US;
    localparam int TW         = $clog2(SPAN_US + 1);
    localparam int DQ_W       = (MAX_BYTES + 1) * 8;
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_BYTES);

    tx_state_e        state, state_n;
    burst_sel_e       burst_q;
    logic [DQ_W-1:0]  data_q;
    logic [7:0]       cur_byte;
    logic [3:0]       bit_idx;
    logic             parity;
    logic             in_burst;
    logic [LEN_W-1:0] bytes_left;
    logic [TW-1:0]    seg_len;
    logic             run, tick, seg_end;
    logic             cur_bit, last_bit, more_bytes;

    assign run        = (state != ST_IDLE) && (state != ST_FINISH);
    assign last_bit   = bit_idx[3];
    assign cur_bit    = last_bit ? parity : cur_byte[7];
    assign more_bytes = bytes_left > LEN_W'(1);

    diseqc_us_tick #(.RATIO(TICK_RATIO)) u_tick (
        .clk (clk), .rst_n (rst_n), .run (run), .tick (tick)
    );

    diseqc_seg_timer #(.TW(TW)) u_timer (
        .clk (clk), .rst_n (rst_n), .run (run), .tick (tick),
        .seg_len (seg_len), .seg_end (seg_end)
    );

    // interval length of the current state, in ticks
    always_comb begin
        unique case (state)
            ST_LEAD_GAP, ST_TRAIL_GAP: seg_len = TW'(GAP_US);
            ST_BIT_ON:     seg_len = cur_bit ? TW'(SHORT_US) : TW'(LONG_US);
            ST_BIT_OFF:    seg_len = cur_bit ? TW'(LONG_US)  : TW'(SHORT_US);
            ST_TONE_BURST: seg_len = TW'(TONE_US);
            ST_TAIL_GAP:   seg_len = TW'(TAIL_US);
            default:       seg_len = TW'(1);
        endcase
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:       if (start) state_n = ST_LEAD_GAP;
            ST_LEAD_GAP:   if (seg_end)
                               state_n = (bytes_left != '0) ? ST_BIT_ON : ST_TRAIL_GAP;
            ST_BIT_ON:     if (seg_end) state_n = ST_BIT_OFF;
            ST_BIT_OFF:    if (seg_end) begin
                               if (!last_bit)      state_n = ST_BIT_ON;
                               else if (in_burst)  state_n = ST_TAIL_GAP;
                               else if (more_bytes) state_n = ST_BIT_ON;
                               else                state_n = ST_TRAIL_GAP;
                           end
            ST_TRAIL_GAP:  if (seg_end) begin
                               unique case (burst_q)
                                   BURST_TONE: state_n = ST_TONE_BURST;
                                   BURST_BYTE: state_n = ST_BIT_ON;
                                   default:    state_n = ST_FINISH;
                               endcase
                           end
            ST_TONE_BURST: if (seg_end) state_n = ST_TAIL_GAP;
            ST_TAIL_GAP:   if (seg_end) state_n = ST_FINISH;
            ST_FINISH:     state_n = ST_IDLE;
            default:       state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // symbol datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_q    <= BURST_NONE;
            data_q     <= '0;
            cur_byte   <= '0;
            bit_idx    <= '0;
            parity     <= 1'b1;
            in_burst   <= 1'b0;
            bytes_left <= '0;
        end else if (state == ST_IDLE && start) begin
            burst_q    <= burst_sel_e'(burst_sel);
            data_q     <= {8'h00, msg_data};
            cur_byte   <= msg_data[7:0];
            bit_idx    <= '0;
            parity     <= 1'b1;
            in_burst   <= 1'b0;
            bytes_left <= (msg_len > LEN_CAP) ? LEN_CAP : msg_len;
        end else if (seg_end) begin
            if (state == ST_BIT_OFF) begin
                if (!last_bit) begin
                    parity   <= parity ^ cur_byte[7];
                    cur_byte <= {cur_byte[6:0], 1'b0};
                    bit_idx  <= bit_idx + 4'd1;
                end else begin
                    parity   <= 1'b1;
                    bit_idx  <= '0;
                    cur_byte <= data_q[15:8];
                    data_q   <= {8'h00, data_q[DQ_W-1:8]};
                    if (bytes_left != '0) bytes_left <= bytes_left - LEN_W'(1);
                end
            end else if (state == ST_TRAIL_GAP && burst_q == BURST_BYTE) begin
                cur_byte <= 8'hFF;
                bit_idx  <= '0;
                parity   <= 1'b1;
                in_burst <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tone_en = (state == ST_BIT_ON) || (state == ST_TONE_BURST);
        busy    = (state != ST_IDLE);
        done    = (state == ST_FINISH);
    end
endmodule

// File: rtl/diseqc_env_tx_chk.sv
module diseqc_env_tx_chk #(
    parameter int RATIO = 1,
    parameter int SHORT = 1,
    parameter int LONG  = 1,
    parameter int TONE  = 1
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic tone_en,
    input logic busy,
    input logic done
);
    int unsigned on_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       on_run <= 0;
        else if (tone_en) on_run <= on_run + 1;
        else              on_run <= 0;
    end

    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_after_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_start_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    assert_hold_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_tone_needs_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tone_en |-> busy);

    // R1 R2 R6 R13: every high pulse has one of the legal widths
    assert_on_width_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tone_en) && on_run != 0) |->
        (on_run == SHORT * RATIO || on_run == LONG * RATIO || on_run == TONE * RATIO));
endmodule

bind diseqc_env_tx diseqc_env_tx_chk #(
    .RATIO (TICK_RATIO),
    .SHORT (SHORT_US),
    .LONG  (LONG_US),
    .TONE  (TONE_US)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tone_en (tone_en),
    .busy    (busy),
    .done    (done)
);

// File: tb/diseqc_env_tx_bench.sv
`timescale 1ns/1ps
module diseqc_env_tx_bench;
    localparam int CLK_HZ = 2_000_000;
    localparam int RATIO  = CLK_HZ / 1_000_000;
    localparam int MAXB   = 3;
    localparam int LW     = 4;
    localparam int SH = 3, LG = 5, GP = 8, TN = 11, TL = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [LW-1:0]     msg_len = '0;
    logic [MAXB*8-1:0] msg_data = '0;
    logic [1:0]        burst_sel = 2'b00;
    logic              tone_en, busy, done;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    bit exp_lvl [0:127];
    int exp_cyc [0:127];
    int n_seg;

    always #2.5 clk = ~clk;

    diseqc_env_tx #(
        .CLK_HZ (CLK_HZ), .MAX_BYTES (MAXB), .LEN_W (LW),
        .SHORT_US (SH), .LONG_US (LG), .GAP_US (GP), .TONE_US (TN), .TAIL_US (TL)
    ) u_diseqc_env_tx (
        .clk (clk), .rst_n (rst_n), .start (start), .msg_len (msg_len),
        .msg_data (msg_data), .burst_sel (burst_sel),
        .tone_en (tone_en), .busy (busy), .done (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic add_seg(input bit lvl, input int units);
        exp_lvl[n_seg] = lvl;
        exp_cyc[n_seg] = units * RATIO;
        n_seg++;
    endtask

    task automatic add_bit(input bit b);
        add_seg(1'b1, b ? SH : LG);
        add_seg(1'b0, b ? LG : SH);
    endtask

    task automatic add_byte(input logic [7:0] b);
        bit par = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            par ^= b[i];
            add_bit(b[i]);
        end
        add_bit(par);
    endtask

    // Builds the expected gate, starts a frame and compares every cycle.
    // poke >= 0 issues a second start at that cycle of the frame.
    task automatic run_frame(input int len, input logic [MAXB*8-1:0] data,
                             input logic [1:0] sel, input int poke, input string req);
        int eff, total, k, bad, first_k, first_act, first_exp, busy_bad;
        eff = (len > MAXB) ? MAXB : len;
        n_seg = 0;
        add_seg(1'b0, GP);
        for (int b = 0; b < eff; b++) add_byte(data[b*8 +: 8]);
        add_seg(1'b0, GP);
        if (sel == 2'b01) begin add_seg(1'b1, TN); add_seg(1'b0, TL); end
        else if (sel == 2'b10) begin add_byte(8'hFF); add_seg(1'b0, TL); end
        total = 0;
        for (int s = 0; s < n_seg; s++) total += exp_cyc[s];

        @(negedge clk);
        start = 1'b1; msg_len = LW'(len); msg_data = data; burst_sel = sel;
        @(negedge clk);
        start = 1'b0;
        k = 0; bad = 0; busy_bad = 0; first_k = -1; first_act = 0; first_exp = 0;
        for (int s = 0; s < n_seg; s++) begin
            for (int c = 0; c < exp_cyc[s]; c++) begin
                if (tone_en !== exp_lvl[s]) begin
                    if (first_k < 0) begin
                        first_k = k; first_act = int'(tone_en); first_exp = int'(exp_lvl[s]);
                    end
                    bad++;
                end
                if (busy !== 1'b1 || done !== 1'b0) busy_bad++;
                if (k == poke) begin
                    start = 1'b1; msg_len = 4'd1; msg_data = '1; burst_sel = 2'b01;
                end else if (k == poke + 1) begin
                    start = 1'b0;
                end
                k++;
                @(negedge clk);
            end
        end
        start = 1'b0;
        if (first_k >= 0)
            $display("FAIL %s first gate mismatch at cycle %0d: actual=%0d expected=%0d",
                     req, first_k, first_act, first_exp);
        check(bad == 0, req, "gate mismatching cycles", bad, 0);
        check(busy_bad == 0, "R10", "busy/done during frame", busy_bad, 0);
        check(done === 1'b1 && busy === 1'b1, "R12", "done at frame end", int'(done), 1);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0 && tone_en === 1'b0, "R12",
              "idle after done", int'({done, busy, tone_en}), 0);
    endtask

    task automatic t_reset_state;
        check(tone_en === 1'b0 && busy === 1'b0 && done === 1'b0, "R11",
              "outputs in reset", int'({tone_en, busy, done}), 0);
    endtask

    task automatic t_async_reset;
        @(negedge clk);
        start = 1'b1; msg_len = 4'd1; msg_data = '0; burst_sel = 2'b01;
        @(negedge clk);
        start = 1'b0;
        repeat (GP * RATIO + 2) @(negedge clk);
        check(tone_en === 1'b1, "R2", "zero bit on before reset", int'(tone_en), 1);
        #1 rst_n = 1'b0;
        #1 check(tone_en === 1'b0 && busy === 1'b0 && done === 1'b0, "R11",
                 "outputs right after async reset", int'({tone_en, busy, done}), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && tone_en === 1'b0, "R11", "idle after reset release",
              int'({busy, tone_en}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        // R1 R2 R3 R4 R7 R13: mixed bits, odd parity, no burst
        run_frame(1, 24'h0000E2, 2'b00, -1, "R3");
        // R6: two bytes then continuous tone burst
        run_frame(2, 24'h00015A, 2'b01, -1, "R6");
        // R5 R8: zero length with byte-form burst
        run_frame(0, 24'h000000, 2'b10, -1, "R5");
        // R7 R8: reserved selector behaves as no burst
        run_frame(0, 24'h000000, 2'b11, -1, "R7");
        // R9: length 7 clamped to 3 bytes
        run_frame(7, 24'h80C301, 2'b00, -1, "R9");
        // R10: second start mid-frame has no effect
        run_frame(1, 24'h00003C, 2'b00, 40, "R10");
        // R11: asynchronous reset during a tone, then a normal frame (R1 R13)
        t_async_reset();
        run_frame(1, 24'h0000FF, 2'b10, -1, "R1");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule